// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block passes single command or control words between two ports that run on unrelated clocks. It bypasses the data queue. There are two registers, one for each direction. The forward register is loaded from port A and read at port B. The return register is loaded from port B and read at port A.

Each register has an occupancy flag. The writing side sees the flag as an "empty" indication, and the reading side sees it as a "full" indication. A write is taken only while the writer's side sees the register empty. A read marks the register empty again and leaves its contents as they were. The two edges of each flag start in different clock domains. Each one is carried across by a toggle that passes through a multi-stage synchronizer.

On port B the output bus shows either the queue's output word or the forward register, as the port's mailbox select picks. Port A's output always shows the return register. Each port also has an output-enable that tells when its bus should be driven.

Top module: `mbx_pair`

## Requirements
- R1: After reset, both writer-side empty flags are high and both reader-side full flags are low. Both registers hold zero, so a_dout reads 0, and b_dout reads 0 when b_mbx is 1.
- R2: A port-A operation with a_cs=1, a_en=1, a_wr=1 and a_mbx=1, made while a_m1_empty=1, loads a_din into the forward register on the rising clk_a edge. The forward register is shown on b_dout when b_mbx=1.
- R3: A port-B operation with b_cs=1, b_en=1, b_wr=1 and b_mbx=1, made while b_m2_empty=1, loads b_din into the return register on the rising clk_b edge. The return register is shown on a_dout.
- R4: An accepted write drives that register's writer-side empty flag low (0 = full) from the same writer clock edge.
- R5: A write attempted while the writer-side empty flag is low is discarded. The register keeps its earlier word and the flag stays low.
- R6: A read takes a_wr=0 or b_wr=0, with cs, en and mbx all 1 on the reading port, and is made while that port's full flag is 1. It drops the full flag from that reader clock edge. The writer-side empty flag returns high within SYNC_STAGES+2 writer clock cycles. A read made while the full flag is 0 has no effect.
- R7: Reading a register leaves its contents unchanged.
- R8: b_dout equals b_fifo_q when b_mbx=0 and equals the forward register when b_mbx=1. a_dout always equals the return register.
- R9: An operation is valid only when both cs and en are 1. A write with cs=0, with en=0 or with mbx=0 leaves the register and both of its flags untouched.
- R10: Each port's output enable is 1 exactly when that port's cs=1 and wr=0.
- R11: After an accepted write, the reader-side full flag rises within SYNC_STAGES+2 reader clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs | input | 1 | Port A chip select, active high |
| a_en | input | 1 | Port A enable, active high |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | WIDTH | Port A write data |
| a_dout | output | WIDTH | Return register contents |
| a_oe | output | 1 | Port A output enable |
| a_m1_empty | output | 1 | Forward register empty, clk_a domain |
| a_m2_full | output | 1 | Return register holds unread mail, clk_a domain |
| b_cs | input | 1 | Port B chip select, active high |
| b_en | input | 1 | Port B enable, active high |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbx | input | 1 | Port B mailbox select; also picks the output source |
| b_din | input | WIDTH | Port B write data |
| b_fifo_q | input | WIDTH | Queue output word shown when b_mbx=0 |
| b_dout | output | WIDTH | Port B output bus |
| b_oe | output | 1 | Port B output enable |
| b_m2_empty | output | 1 | Return register empty, clk_b domain |
| b_m1_full | output | 1 | Forward register holds unread mail, clk_b domain |

## Verification
The bench writes a second word while the first one is still unread. A design that overwrote the register would deliver the later word instead of the earlier one. It also reads while the register is empty and then sends a fresh word. A design that toggled its handshake on that stray read would invert its flags and lose or duplicate the next transfer. The bench writes with chip select, enable or mailbox select missing, which a design with loose decoding would accept. It also checks that data survives a read and that the port-B multiplexer picks the right source, which catches a read that clears the register or a select that is inverted.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned MBX_WIDTH_DEF  = 36;
   localparam int unsigned MBX_STAGES_DEF = 2;

   typedef struct packed {
      logic wr;
      logic rd;
      logic oe;
   } port_op_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[LAST];
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
(
   input  logic     cs,
   input  logic     en,
   input  logic     wr,
   input  logic     mbx,
   output port_op_t op
);
   logic valid;

   always_comb begin
      valid  = cs & en;
      op.wr  = valid & wr & mbx;
      op.rd  = valid & ~wr & mbx;
      op.oe  = cs & ~wr;
   end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
   parameter int unsigned WIDTH  = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_req,
   output logic [WIDTH-1:0] mail,
   output logic             w_empty,
   output logic             r_full
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("mbx_channel: WIDTH must be positive");
      end
   endgenerate

   logic wtog, rtog;
   logic wtog_in_r, rtog_in_w;
   logic w_take, r_take;

   mbx_sync #(.STAGES(STAGES)) u_sync_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wtog), .q(wtog_in_r));

   mbx_sync #(.STAGES(STAGES)) u_sync_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rtog), .q(rtog_in_w));

   assign w_empty = (wtog == rtog_in_w);
   assign r_full  = (wtog_in_r != rtog);
   assign w_take  = wr_req & w_empty;
   assign r_take  = rd_req & r_full;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         mail <= '0;
         wtog <= 1'b0;
      end else if (w_take) begin
         mail <= wdata;
         wtog <= ~wtog;
      end
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)      rtog <= 1'b0;
      else if (r_take) rtog <= ~rtog;
   end

   AST_WR_LOADS: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_req && w_empty) |=> (mail == $past(wdata)));           // R2
   AST_WR_FULLS: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_req && w_empty) |=> !w_empty);                         // R4
   AST_WR_REFUSED: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_req && !w_empty) |=> $stable(mail));                   // R5
   AST_RD_DRAINS: assert property (@(posedge rclk) disable iff (!rst_n)
      (rd_req && r_full) |=> !r_full);                           // R6
   AST_DATA_HELD: assert property (@(posedge rclk) disable iff (!rst_n)
      (r_full && $past(r_full)) |-> $stable(mail));              // R7
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
   import mbx_pkg::*;
#(
   parameter int unsigned WIDTH       = MBX_WIDTH_DEF,
   parameter int unsigned SYNC_STAGES = MBX_STAGES_DEF
) (
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst_n,
   input  logic             a_cs,
   input  logic             a_en,
   input  logic             a_wr,
   input  logic             a_mbx,
   input  logic [WIDTH-1:0] a_din,
   output logic [WIDTH-1:0] a_dout,
   output logic             a_oe,
   output logic             a_m1_empty,
   output logic             a_m2_full,
   input  logic             b_cs,
   input  logic             b_en,
   input  logic             b_wr,
   input  logic             b_mbx,
   input  logic [WIDTH-1:0] b_din,
   input  logic [WIDTH-1:0] b_fifo_q,
   output logic [WIDTH-1:0] b_dout,
   output logic             b_oe,
   output logic             b_m2_empty,
   output logic             b_m1_full
);
   port_op_t op_a, op_b;
   logic [WIDTH-1:0] mail1, mail2;

   mbx_port_dec u_dec_a (.cs(a_cs), .en(a_en), .wr(a_wr), .mbx(a_mbx), .op(op_a));
   mbx_port_dec u_dec_b (.cs(b_cs), .en(b_en), .wr(b_wr), .mbx(b_mbx), .op(op_b));

   mbx_channel #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_fwd (
      .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
      .wr_req(op_a.wr), .wdata(a_din), .rd_req(op_b.rd),
      .mail(mail1), .w_empty(a_m1_empty), .r_full(b_m1_full));

   mbx_channel #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_ret (
      .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
      .wr_req(op_b.wr), .wdata(b_din), .rd_req(op_a.rd),
      .mail(mail2), .w_empty(b_m2_empty), .r_full(a_m2_full));

   assign a_dout = mail2;
   assign a_oe   = op_a.oe;
   assign b_dout = b_mbx ? mail1 : b_fifo_q;
   assign b_oe   = op_b.oe;
endmodule

// File: tb/mbx_pair_tb.sv
module mbx_pair_tb;
   localparam int W = 36;
   localparam int ST = 2;

   logic clk_a = 0, clk_b = 0, rst_n = 0;
   logic a_cs = 0, a_en = 0, a_wr = 0, a_mbx = 0;
   logic b_cs = 0, b_en = 0, b_wr = 0, b_mbx = 0;
   logic [W-1:0] a_din = '0, b_din = '0, b_fifo_q = '0;
   logic [W-1:0] a_dout, b_dout;
   logic a_oe, b_oe, a_m1_empty, a_m2_full, b_m2_empty, b_m1_full;

   int checks = 0, errors = 0;
   logic [W-1:0] exp_m1[$];
   logic [W-1:0] exp_m2[$];

   always #4 clk_a = ~clk_a;
   always #6.5 clk_b = ~clk_b;

   mbx_pair #(.WIDTH(W), .SYNC_STAGES(ST)) u_dut (.*);

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic a_op(input logic cs, en, wr, mbx, input logic [W-1:0] d);
      @(negedge clk_a);
      a_cs = cs; a_en = en; a_wr = wr; a_mbx = mbx; a_din = d;
      @(negedge clk_a);
      a_cs = 0; a_en = 0; a_wr = 0; a_mbx = 0;
   endtask

   task automatic b_op(input logic cs, en, wr, mbx, input logic [W-1:0] d);
      @(negedge clk_b);
      b_cs = cs; b_en = en; b_wr = wr; b_mbx = mbx; b_din = d;
      @(negedge clk_b);
      b_cs = 0; b_en = 0; b_wr = 0; b_mbx = 0;
   endtask

   // driver: forward mail
   task automatic send_m1(input logic [W-1:0] d);
      a_op(1, 1, 1, 1, d);
      chk(a_m1_empty == 0, "R4 a_m1_empty after write", {35'd0, a_m1_empty}, 0);
      exp_m1.push_back(d);
   endtask

   task automatic send_m2(input logic [W-1:0] d);
      b_op(1, 1, 1, 1, d);
      chk(b_m2_empty == 0, "R4 b_m2_empty after write", {35'd0, b_m2_empty}, 0);
      exp_m2.push_back(d);
   endtask

   // monitor: forward mail at port B
   task automatic recv_m1();
      logic [W-1:0] e;
      int n = 0;
      e = exp_m1.pop_front();
      while (!b_m1_full && n < 10) begin @(negedge clk_b); n++; end
      chk(b_m1_full && n <= ST + 2, "R11 b_m1_full latency", n, ST + 2);
      b_mbx = 1; #1;
      chk(b_dout == e, "R2 forward word on b_dout", b_dout, e);
      b_mbx = 0;
      b_op(1, 1, 0, 1, '0);
      chk(b_m1_full == 0, "R6 b_m1_full drops on read", {35'd0, b_m1_full}, 0);
      b_mbx = 1; #1;
      chk(b_dout == e, "R7 forward word kept after read", b_dout, e);
      b_mbx = 0;
      n = 0;
      while (!a_m1_empty && n < 10) begin @(negedge clk_a); n++; end
      chk(a_m1_empty && n <= ST + 2, "R6 a_m1_empty returns", n, ST + 2);
   endtask

   task automatic recv_m2();
      logic [W-1:0] e;
      int n = 0;
      e = exp_m2.pop_front();
      while (!a_m2_full && n < 10) begin @(negedge clk_a); n++; end
      chk(a_m2_full && n <= ST + 2, "R11 a_m2_full latency", n, ST + 2);
      chk(a_dout == e, "R3 return word on a_dout", a_dout, e);
      a_op(1, 1, 0, 1, '0);
      chk(a_m2_full == 0, "R6 a_m2_full drops on read", {35'd0, a_m2_full}, 0);
      chk(a_dout == e, "R7 return word kept after read", a_dout, e);
      n = 0;
      while (!b_m2_empty && n < 10) begin @(negedge clk_b); n++; end
      chk(b_m2_empty && n <= ST + 2, "R6 b_m2_empty returns", n, ST + 2);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk_b);
      repeat (2) @(negedge clk_a);
   endtask

   initial begin : watchdog
      #400000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk_b);
      rst_n = 1;
      @(negedge clk_a);
      // R1
      chk(a_m1_empty == 1, "R1 a_m1_empty", {35'd0, a_m1_empty}, 1);
      chk(b_m2_empty == 1, "R1 b_m2_empty", {35'd0, b_m2_empty}, 1);
      chk(a_m2_full == 0, "R1 a_m2_full", {35'd0, a_m2_full}, 0);
      chk(b_m1_full == 0, "R1 b_m1_full", {35'd0, b_m1_full}, 0);
      chk(a_dout == '0, "R1 a_dout", a_dout, '0);
      b_mbx = 1; #1;
      chk(b_dout == '0, "R1 b_dout mailbox", b_dout, '0);
      b_mbx = 0;

      // R2 basic transfers
      send_m1(36'h1_2345_6789); recv_m1();
      send_m1(36'hF_FFFF_FFFF); recv_m1();
      // R3
      send_m2(36'hA_5A5A_5A5A); recv_m2();
      send_m2(36'h0_0000_0001); recv_m2();

      // R5 write refused while full
      send_m1(36'h3_1111_0000);
      a_op(1, 1, 1, 1, 36'hB_AD0B_AD0B);
      chk(a_m1_empty == 0, "R5 a_m1_empty stays low", {35'd0, a_m1_empty}, 0);
      recv_m1();
      send_m2(36'h4_2222_0000);
      b_op(1, 1, 1, 1, 36'hD_EADD_EADD);
      recv_m2();

      // R9 invalid writes ignored
      a_op(0, 1, 1, 1, 36'h7_7777_7777);
      a_op(1, 0, 1, 1, 36'h7_7777_7777);
      a_op(1, 1, 1, 0, 36'h7_7777_7777);
      settle();
      chk(a_m1_empty == 1, "R9 a_m1_empty untouched", {35'd0, a_m1_empty}, 1);
      chk(b_m1_full == 0, "R9 b_m1_full untouched", {35'd0, b_m1_full}, 0);
      b_mbx = 1; #1;
      chk(b_dout == 36'h3_1111_0000, "R9 forward word untouched", b_dout, 36'h3_1111_0000);
      b_mbx = 0;
      b_op(0, 1, 1, 1, 36'h6_6666_6666);
      b_op(1, 0, 1, 1, 36'h6_6666_6666);
      settle();
      chk(b_m2_empty == 1, "R9 b_m2_empty untouched", {35'd0, b_m2_empty}, 1);
      chk(a_dout == 36'h4_2222_0000, "R9 return word untouched", a_dout, 36'h4_2222_0000);

      // R6 read while empty has no effect
      b_op(1, 1, 0, 1, '0);
      a_op(1, 1, 0, 1, '0);
      settle();
      chk(a_m1_empty == 1, "R6 empty read leaves a_m1_empty", {35'd0, a_m1_empty}, 1);
      chk(b_m1_full == 0, "R6 empty read leaves b_m1_full", {35'd0, b_m1_full}, 0);
      chk(b_m2_empty == 1, "R6 empty read leaves b_m2_empty", {35'd0, b_m2_empty}, 1);
      send_m1(36'h5_0F0F_0F0F); recv_m1();
      send_m2(36'h8_F0F0_F0F0); recv_m2();

      // R8 mux, R10 output enables
      @(negedge clk_b);
      b_fifo_q = 36'h9_1234_ABCD; b_cs = 1; b_wr = 0; b_mbx = 0; #1;
      chk(b_dout == 36'h9_1234_ABCD, "R8 b_dout shows queue", b_dout, 36'h9_1234_ABCD);
      chk(b_oe == 1, "R10 b_oe on read", {35'd0, b_oe}, 1);
      b_mbx = 1; #1;
      chk(b_dout == 36'h5_0F0F_0F0F, "R8 b_dout shows forward", b_dout, 36'h5_0F0F_0F0F);
      b_wr = 1; #1;
      chk(b_oe == 0, "R10 b_oe off on write", {35'd0, b_oe}, 0);
      b_cs = 0; b_wr = 0; b_mbx = 0; #1;
      chk(b_oe == 0, "R10 b_oe off unselected", {35'd0, b_oe}, 0);
      a_cs = 1; a_wr = 0; a_mbx = 0; #1;
      chk(a_oe == 1, "R10 a_oe on read", {35'd0, a_oe}, 1);
      chk(a_dout == 36'h8_F0F0_F0F0, "R8 a_dout shows return", a_dout, 36'h8_F0F0_F0F0);
      a_wr = 1; #1;
      chk(a_oe == 0, "R10 a_oe off on write", {35'd0, a_oe}, 0);
      a_cs = 0; a_wr = 0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule